// File: doc/BRIEF.md
# Serial Programmer Command Interpreter

This block turns a host byte stream into in-system programming traffic for a target device. Each host command is one letter, sometimes followed by argument bytes. The block keeps a 16-bit word address and the code of the selected target. It turns each programming command into one or more 32-bit serial instruction frames, which it hands to a separate shifter through a request/response handshake. It then sends reply bytes back to the host: either data read from the target, a carriage return (0x0D) when the command completes, or `?` (0x3F) when the command is unknown or not allowed.

Several behaviours depend on the selected target. Byte-wide targets pack the high address bits together with an access-kind code into the second frame byte. Targets that use page-mode writes skip the settle time after each byte write. Write, erase, page and raw commands are followed by a settle wait of a set number of clock cycles. No new frame and no reply is produced until that wait has run out. The UART, the serial shifter and the sequence that enables programming mode are separate blocks.

Top module: `spiprog_cmd`

## Requirements
- R1: After reset no frame request or reply byte is presented, the receive side is ready, the word address is 0 and the device code is 0x00, which is not a supported code.
- R2: An ESC byte (0x1B) received while waiting for a command letter is dropped with no reply.
- R3: An unknown letter is answered with 0x3F. A programming letter (P L c C R D d e s m :) sent while the stored device code is unsupported is answered with 0x3F at once, and its argument bytes are not consumed: they are decoded as new commands.
- R4: `T` (0x54) stores the next byte as the device code and answers 0x0D. `A` (0x41) loads the word address from the next two bytes, high byte first, and answers 0x0D.
- R5: `c` (0x63) issues frame {0x40, addrH, addrL, data} and `C` (0x43) issues {0x48, addrH, addrL, data}. Both answer 0x0D, and only `C` adds one to the address.
- R6: `R` (0x52) issues {0x28, addrH, addrL, 0x00} and then {0x20, addrH, addrL, 0x00}. It forwards the response byte of each frame in that order, then adds one to the address.
- R7: With device code 0x86 (byte-wide), the second frame byte is (addrH<<3)|k, with k = 1 for a program read, 2 for a program write, 5 for a data read and 6 for a data write. `R` issues one frame, forwards one byte and leaves the address unchanged. `C` consumes its data byte and answers 0x3F.
- R8: `d` (0x64) issues {0xA0, addrH, addrL, 0x00} and forwards its response byte. `D` (0x44) issues {0xC0, addrH, addrL, data} and answers 0x0D.
- R9: `e` (0x65) issues {0xAC, 0x80, 0x04, 0x00} and answers 0x0D. `s` (0x73) issues {0x30, 0x00, n, 0x00} for n = 2, 1, 0 in that order and forwards each response byte.
- R10: `m` (0x6D) issues {0x4C, addrH, addrL, 0x00}. The 0x0D after `c`, `C` and `D` comes at least WRITE_WAIT cycles after the frame. After `e`, `m` and `:` it comes at least LONG_WAIT cycles after the frame. Page-mode devices (0x40, 0x41) skip the wait after `c` and `C`.
- R11: `:` (0x3A) takes three bytes, issues them as the first three frame bytes with 0x00 last, forwards the response byte, waits and answers 0x0D.
- R12: `S` (0x53) returns "SERPRGM". `V` (0x56) returns '3','1' and `v` (0x76) returns '1','2' (0x30 plus the revision digits). `p` (0x70) returns 'S'. `t` (0x74) returns 0x12 0x13 0x20 0x28 0x38 0x48 0x86 0x00. None of these needs a device code.
- R13: `P` (0x50) answers 0x0D when the device code is one of 0x12 0x13 0x20 0x28 0x38 0x48 0x86 0x40 0x41, and 0x3F otherwise. `L` (0x4C) answers 0x0D.
- R14: A frame request and a reply byte each hold their value until accepted. No frame and no reply is presented while the settle wait runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte available |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block accepts the host byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Host side accepts the reply byte |
| frm_valid | output | 1 | Frame request to the shifter |
| frm_data | output | 32 | Frame, first byte in bits 31:24 |
| frm_ready | input | 1 | Shifter accepts the frame |
| rsp_valid | input | 1 | One-cycle pulse carrying the fourth received byte |
| rsp_data | input | 8 | Fourth byte shifted in from the target |

## Verification
The hardest situations to reach are those that depend on the stored device code combined with a command. Examples are a rejected `C` that must still swallow its data byte, a gated command whose argument must instead be decoded as a fresh letter, and the page-mode skip of the settle wait. The stimulus selects each device class in turn with `T` and then replays the same commands. Each is followed by a probe letter such as `p`, whose reply shows whether the preceding byte was consumed. Settle waits are checked by timing the gap from the frame handshake to the 0x0D, while both ready inputs are throttled.

// File: rtl/spiprog_pkg.sv
package spiprog_pkg;

    localparam logic [7:0] CH_CR  = 8'h0D;
    localparam logic [7:0] CH_ERR = 8'h3F;
    localparam logic [7:0] CH_ESC = 8'h1B;

    localparam logic [7:0] CMD_DEV   = 8'h54;
    localparam logic [7:0] CMD_ADDR  = 8'h41;
    localparam logic [7:0] CMD_WLO   = 8'h63;
    localparam logic [7:0] CMD_WHI   = 8'h43;
    localparam logic [7:0] CMD_RPROG = 8'h52;
    localparam logic [7:0] CMD_WDATA = 8'h44;
    localparam logic [7:0] CMD_RDATA = 8'h64;
    localparam logic [7:0] CMD_ERASE = 8'h65;
    localparam logic [7:0] CMD_SIG   = 8'h73;
    localparam logic [7:0] CMD_PAGE  = 8'h6D;
    localparam logic [7:0] CMD_RAW   = 8'h3A;
    localparam logic [7:0] CMD_ENTER = 8'h50;
    localparam logic [7:0] CMD_LEAVE = 8'h4C;
    localparam logic [7:0] CMD_IDENT = 8'h53;
    localparam logic [7:0] CMD_SWVER = 8'h56;
    localparam logic [7:0] CMD_HWVER = 8'h76;
    localparam logic [7:0] CMD_KIND  = 8'h70;
    localparam logic [7:0] CMD_LIST  = 8'h74;

    localparam logic [7:0] DEV_BYTEWIDE = 8'h86;
    localparam logic [7:0] DEV_PAGE_A   = 8'h40;
    localparam logic [7:0] DEV_PAGE_B   = 8'h41;
    localparam int         LIST_LEN     = 7;

    typedef enum logic [3:0] {
        ST_CMD, ST_ARG, ST_GO, ST_FREQ, ST_FRSP, ST_FTX, ST_WAIT, ST_END, ST_STR
    } state_e;

    typedef struct packed {
        state_e      st;
        logic [7:0]  cmd;
        logic [7:0]  a0;
        logic [7:0]  a1;
        logic [7:0]  a2;
        logic [1:0]  argn;
        logic [1:0]  step;
        logic [15:0] addr;
        logic [7:0]  dev;
        logic [7:0]  rsp;
        logic [3:0]  idx;
        logic [7:0]  endb;
    } ctl_t;

    function automatic logic [7:0] dev_list(input int i);
        case (i)
            0: return 8'h12;
            1: return 8'h13;
            2: return 8'h20;
            3: return 8'h28;
            4: return 8'h38;
            5: return 8'h48;
            6: return DEV_BYTEWIDE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_page(input logic [7:0] d);
        return (d == DEV_PAGE_A) || (d == DEV_PAGE_B);
    endfunction

    function automatic logic is_supported(input logic [7:0] d);
        logic hit;
        hit = is_page(d);
        for (int i = 0; i < LIST_LEN; i++)
            if (dev_list(i) == d) hit = 1'b1;
        return hit;
    endfunction

    function automatic logic is_info(input logic [7:0] c);
        return (c == CMD_IDENT) || (c == CMD_SWVER) || (c == CMD_HWVER) ||
               (c == CMD_KIND)  || (c == CMD_LIST);
    endfunction

    function automatic logic is_gated(input logic [7:0] c);
        return (c == CMD_ENTER) || (c == CMD_LEAVE) || (c == CMD_WLO) ||
               (c == CMD_WHI)   || (c == CMD_RPROG) || (c == CMD_WDATA) ||
               (c == CMD_RDATA) || (c == CMD_ERASE) || (c == CMD_SIG) ||
               (c == CMD_PAGE)  || (c == CMD_RAW);
    endfunction

    function automatic logic [1:0] arg_count(input logic [7:0] c);
        case (c)
            CMD_DEV, CMD_WLO, CMD_WHI, CMD_WDATA: return 2'd1;
            CMD_ADDR:                             return 2'd2;
            CMD_RAW:                              return 2'd3;
            default:                              return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] frame_count(input logic [7:0] c, input logic bw);
        case (c)
            CMD_RPROG: return bw ? 2'd1 : 2'd2;
            CMD_SIG:   return 2'd3;
            default:   return 2'd1;
        endcase
    endfunction

    function automatic logic returns_data(input logic [7:0] c);
        return (c == CMD_RPROG) || (c == CMD_RDATA) || (c == CMD_SIG) || (c == CMD_RAW);
    endfunction

endpackage

// File: rtl/spiprog_wait_timer.sv
module spiprog_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          busy
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(val)));

endmodule

// File: rtl/spiprog_frame_build.sv
module spiprog_frame_build
    import spiprog_pkg::*;
(
    input  logic [7:0]  cmd,
    input  logic [1:0]  step,
    input  logic [15:0] addr,
    input  logic [7:0]  a0,
    input  logic [7:0]  a1,
    input  logic [7:0]  a2,
    input  logic        byte_wide,
    output logic [31:0] frame
);
    logic [7:0] op, hi, last;
    logic [2:0] kind;

    always_comb begin
        op   = 8'h00;
        kind = 3'd0;
        last = 8'h00;
        case (cmd)
            CMD_WLO:   begin op = 8'h40; kind = 3'd2; last = a0; end
            CMD_WHI:   begin op = 8'h48; kind = 3'd2; last = a0; end
            CMD_RPROG: begin op = (step == 2'd0) ? 8'h28 : 8'h20; kind = 3'd1; end
            CMD_RDATA: begin op = 8'hA0; kind = 3'd5; end
            CMD_WDATA: begin op = 8'hC0; kind = 3'd6; last = a0; end
            default:   ;
        endcase
        hi = (byte_wide && kind != 3'd0) ? ({addr[12:8], 3'b000} | {5'b0, kind})
                                         : addr[15:8];
        frame = {op, hi, addr[7:0], last};
        case (cmd)
            CMD_ERASE: frame = 32'hAC80_0400;
            CMD_SIG:   frame = {8'h30, 8'h00, 6'd0, 2'd2 - step, 8'h00};
            CMD_PAGE:  frame = {8'h4C, addr, 8'h00};
            CMD_RAW:   frame = {a0, a1, a2, 8'h00};
            default:   ;
        endcase
    end

endmodule

// File: rtl/spiprog_reply_rom.sv
module spiprog_reply_rom
    import spiprog_pkg::*;
#(
    parameter int SW_MAJ = 3,
    parameter int SW_MIN = 1,
    parameter int HW_MAJ = 1,
    parameter int HW_MIN = 2
) (
    input  logic [7:0] cmd,
    input  logic [3:0] idx,
    output logic [7:0] data,
    output logic [3:0] len
);
    localparam logic [55:0] ID_TEXT = "SERPRGM";

    always_comb begin
        data = 8'h00;
        len  = 4'd1;
        case (cmd)
            CMD_IDENT: begin
                len  = 4'd7;
                data = (idx < 4'd7) ? ID_TEXT[8*(6-int'(idx)) +: 8] : 8'h00;
            end
            CMD_SWVER: begin
                len  = 4'd2;
                data = (idx == 4'd0) ? 8'(8'h30 + SW_MAJ) : 8'(8'h30 + SW_MIN);
            end
            CMD_HWVER: begin
                len  = 4'd2;
                data = (idx == 4'd0) ? 8'(8'h30 + HW_MAJ) : 8'(8'h30 + HW_MIN);
            end
            CMD_KIND: data = 8'h53;
            CMD_LIST: begin
                len  = 4'(LIST_LEN + 1);
                data = dev_list(int'(idx));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spiprog_cmd.sv
module spiprog_cmd
    import spiprog_pkg::*;
#(
    parameter int WRITE_WAIT = 64,
    parameter int LONG_WAIT  = 200,
    parameter int SW_MAJ     = 3,
    parameter int SW_MIN     = 1,
    parameter int HW_MAJ     = 1,
    parameter int HW_MIN     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        frm_valid,
    output logic [31:0] frm_data,
    input  logic        frm_ready,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_data
);
    localparam int MAXW = (LONG_WAIT > WRITE_WAIT) ? LONG_WAIT : WRITE_WAIT;
    localparam int CW   = $clog2(MAXW + 1);

    ctl_t s_d, s_q;

    logic          t_load, t_busy;
    logic [CW-1:0] t_val, wv;
    logic          bw, last_frame, frame_done, fin_inc, fin_cr;
    logic [7:0]    rom_data;
    logic [3:0]    rom_len;

    spiprog_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .busy(t_busy)
    );

    spiprog_frame_build u_frame (
        .cmd(s_q.cmd), .step(s_q.step), .addr(s_q.addr),
        .a0(s_q.a0), .a1(s_q.a1), .a2(s_q.a2),
        .byte_wide(bw), .frame(frm_data)
    );

    spiprog_reply_rom #(
        .SW_MAJ(SW_MAJ), .SW_MIN(SW_MIN), .HW_MAJ(HW_MAJ), .HW_MIN(HW_MIN)
    ) u_rom (
        .cmd(s_q.cmd), .idx(s_q.idx), .data(rom_data), .len(rom_len)
    );

    assign bw         = (s_q.dev == DEV_BYTEWIDE);
    assign last_frame = (s_q.step == frame_count(s_q.cmd, bw) - 2'd1);
    assign fin_inc    = (s_q.cmd == CMD_WHI) || ((s_q.cmd == CMD_RPROG) && !bw);
    assign fin_cr     = !((s_q.cmd == CMD_RPROG) || (s_q.cmd == CMD_RDATA) ||
                          (s_q.cmd == CMD_SIG));

    always_comb begin
        case (s_q.cmd)
            CMD_WLO, CMD_WHI: wv = is_page(s_q.dev) ? '0 : CW'(WRITE_WAIT);
            CMD_WDATA:        wv = CW'(WRITE_WAIT);
            CMD_ERASE, CMD_PAGE, CMD_RAW: wv = CW'(LONG_WAIT);
            default:          wv = '0;
        endcase
    end

    always_comb begin
        s_d        = s_q;
        t_load     = 1'b0;
        t_val      = wv;
        frame_done = 1'b0;
        rx_ready   = (s_q.st == ST_CMD) || (s_q.st == ST_ARG);
        tx_valid   = 1'b0;
        tx_data    = 8'h00;
        frm_valid  = 1'b0;

        case (s_q.st)
            ST_CMD: if (rx_valid) begin
                s_d.cmd  = rx_data;
                s_d.argn = 2'd0;
                s_d.step = 2'd0;
                s_d.idx  = 4'd0;
                if (rx_data == CH_ESC)
                    s_d.st = ST_CMD;
                else if (is_info(rx_data))
                    s_d.st = ST_STR;
                else if (rx_data == CMD_DEV || rx_data == CMD_ADDR)
                    s_d.st = ST_ARG;
                else if (!is_gated(rx_data) || !is_supported(s_q.dev)) begin
                    s_d.endb = CH_ERR;
                    s_d.st   = ST_END;
                end else if (arg_count(rx_data) != 2'd0)
                    s_d.st = ST_ARG;
                else
                    s_d.st = ST_GO;
            end
            ST_ARG: if (rx_valid) begin
                case (s_q.argn)
                    2'd0:    s_d.a0 = rx_data;
                    2'd1:    s_d.a1 = rx_data;
                    default: s_d.a2 = rx_data;
                endcase
                s_d.argn = s_q.argn + 2'd1;
                if (s_q.argn == arg_count(s_q.cmd) - 2'd1) s_d.st = ST_GO;
            end
            ST_GO: begin
                s_d.endb = CH_CR;
                s_d.st   = ST_FREQ;
                case (s_q.cmd)
                    CMD_DEV:  begin s_d.dev = s_q.a0; s_d.st = ST_END; end
                    CMD_ADDR: begin s_d.addr = {s_q.a0, s_q.a1}; s_d.st = ST_END; end
                    CMD_ENTER, CMD_LEAVE: s_d.st = ST_END;
                    CMD_WHI: if (bw) begin s_d.endb = CH_ERR; s_d.st = ST_END; end
                    default: ;
                endcase
            end
            ST_FREQ: begin
                frm_valid = 1'b1;
                if (frm_ready) s_d.st = ST_FRSP;
            end
            ST_FRSP: if (rsp_valid) begin
                s_d.rsp = rsp_data;
                if (returns_data(s_q.cmd)) s_d.st = ST_FTX;
                else                       frame_done = 1'b1;
            end
            ST_FTX: begin
                tx_valid = 1'b1;
                tx_data  = s_q.rsp;
                if (tx_ready) frame_done = 1'b1;
            end
            ST_WAIT: if (!t_busy) begin
                s_d.endb = CH_CR;
                s_d.st   = ST_END;
            end
            ST_END: begin
                tx_valid = 1'b1;
                tx_data  = s_q.endb;
                if (tx_ready) s_d.st = ST_CMD;
            end
            ST_STR: begin
                tx_valid = 1'b1;
                tx_data  = rom_data;
                if (tx_ready) begin
                    if (s_q.idx == rom_len - 4'd1) s_d.st = ST_CMD;
                    else s_d.idx = s_q.idx + 4'd1;
                end
            end
            default: s_d.st = ST_CMD;
        endcase

        if (frame_done) begin
            if (!last_frame) begin
                s_d.step = s_q.step + 2'd1;
                s_d.st   = ST_FREQ;
            end else begin
                if (fin_inc) s_d.addr = s_q.addr + 16'd1;
                if (wv != '0) begin
                    t_load = 1'b1;
                    s_d.st = ST_WAIT;
                end else if (fin_cr) begin
                    s_d.endb = CH_CR;
                    s_d.st   = ST_END;
                end else
                    s_d.st = ST_CMD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_CMD;
        end else
            s_q <= s_d;
    end

    // R14
    frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data)));

    // R14
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R14
    quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_busy |-> (!frm_valid && !tx_valid));

    // R5
    addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.addr) |-> ($past(s_q.st) == ST_GO || $past(s_q.st) == ST_FRSP ||
                                $past(s_q.st) == ST_FTX));

endmodule

// File: tb/spiprog_cmd_test.sv
module spiprog_cmd_test;

    localparam int WW = 64;
    localparam int LW = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        frm_valid;
    logic [31:0] frm_data;
    logic        frm_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = 8'h00;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_frm_cyc = 0;
    int last_tx_cyc = 0;
    bit finished = 1'b0;

    logic [31:0] exp_frm[$];
    string       exp_frm_tag[$];
    logic [7:0]  exp_tx[$];
    string       exp_tx_tag[$];

    logic [15:0] addr_m = 16'h0000;

    always #2 clk = ~clk;

    spiprog_cmd #(.WRITE_WAIT(WW), .LONG_WAIT(LW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_ready(frm_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] rsp_fn(input logic [31:0] f);
        return f[31:24] ^ f[15:8] ^ f[23:16] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic want_frame(input logic [31:0] f, input string tag, input bit data);
        exp_frm.push_back(f);
        exp_frm_tag.push_back(tag);
        if (data) begin
            exp_tx.push_back(rsp_fn(f));
            exp_tx_tag.push_back(tag);
        end
    endtask

    task automatic want_byte(input logic [7:0] b, input string tag);
        exp_tx.push_back(b);
        exp_tx_tag.push_back(tag);
    endtask

    task automatic send(input logic [7:0] b);
        bit r;
        rx_data  = b;
        rx_valid = 1'b1;
        forever begin
            r = rx_ready;
            @(negedge clk);
            if (r) break;
        end
        rx_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while ((exp_tx.size() != 0 || exp_frm.size() != 0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 5000, tag, 32'(exp_tx.size()), 32'd0);
        repeat (12) @(negedge clk);
    endtask

    task automatic gap_check(input int lo, input int hi, input string tag);
        int g;
        g = last_tx_cyc - last_frm_cyc;
        check(g >= lo && g < hi, tag, 32'(g), 32'(lo));
    endtask

    // Ready throttling, response generation and scoreboard monitor
    initial begin
        bit         pend = 1'b0;
        int         pdly = 0;
        logic [7:0] pdata = 8'h00;
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            if (pend) begin
                if (pdly == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = pdata;
                    pend      = 1'b0;
                end else pdly--;
            end
            tx_ready  = (cyc % 4) != 3;
            frm_ready = (cyc % 3) != 0;
            if (rst_n && tx_valid && tx_ready) begin
                last_tx_cyc = cyc;
                if (exp_tx.size() == 0)
                    check(1'b0, "unexpected reply", 32'(tx_data), 32'hFFFF_FFFF);
                else begin
                    logic [7:0] e;
                    string t;
                    e = exp_tx.pop_front();
                    t = exp_tx_tag.pop_front();
                    check(tx_data == e, t, 32'(tx_data), 32'(e));
                end
            end
            if (rst_n && frm_valid && frm_ready) begin
                last_frm_cyc = cyc;
                pend  = 1'b1;
                pdly  = 2;
                pdata = rsp_fn(frm_data);
                if (exp_frm.size() == 0)
                    check(1'b0, "unexpected frame", frm_data, 32'hFFFF_FFFF);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_frm.pop_front();
                    t = exp_frm_tag.pop_front();
                    check(frm_data == e, t, frm_data, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string id;
        id = "SERPRGM";
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_ready == 1'b1, "R1 rx_ready", 32'(rx_ready), 32'd1);
        check(tx_valid == 1'b0 && frm_valid == 1'b0, "R1 idle outputs",
              32'({tx_valid, frm_valid}), 32'd0);

        // R2 ESC dropped, then p probe (R12)
        want_byte(8'h53, "R2 esc then p");
        send(8'h1B); send(8'h1B); send(8'h70);
        drain("R2 drain");

        // R3 unknown letter
        want_byte(8'h3F, "R3 unknown");
        send(8'h5A);
        drain("R3 drain");
        // R3 gated command with no device: its data byte becomes a command
        want_byte(8'h3F, "R3 gated reject");
        want_byte(8'h53, "R3 arg not consumed");
        send(8'h63); send(8'h70);
        drain("R3 drain2");
        // R13 enter refused without a device
        want_byte(8'h3F, "R13 enter refused");
        send(8'h50);
        drain("R13 drain");

        // R4 select device, enter
        want_byte(8'h0D, "R4 device select");
        send(8'h54); send(8'h38);
        want_byte(8'h0D, "R13 enter accepted");
        send(8'h50);
        // R4 address load
        want_byte(8'h0D, "R4 address load");
        send(8'h41); send(8'h12); send(8'h34);
        drain("R4 drain");
        addr_m = 16'h1234;

        // R5 low write, no increment; settle wait R10
        want_frame({8'h40, addr_m, 8'hAB}, "R5 low write frame", 1'b0);
        want_byte(8'h0D, "R5 low write reply");
        send(8'h63); send(8'hAB);
        drain("R5 drain");
        gap_check(WW, WW + 40, "R10 write wait");
        // R5 high write on same address, increments
        want_frame({8'h48, addr_m, 8'hCD}, "R5 high write frame", 1'b0);
        want_byte(8'h0D, "R5 high write reply");
        send(8'h43); send(8'hCD);
        drain("R5 drain2");
        addr_m++;

        // R6 two program reads
        for (int n = 0; n < 2; n++) begin
            want_frame({8'h28, addr_m, 8'h00}, "R6 read high", 1'b1);
            want_frame({8'h20, addr_m, 8'h00}, "R6 read low", 1'b1);
            send(8'h52);
            drain("R6 drain");
            addr_m++;
        end

        // R8 data read and write
        want_frame({8'hA0, addr_m, 8'h00}, "R8 data read", 1'b1);
        send(8'h64);
        want_frame({8'hC0, addr_m, 8'h77}, "R8 data write", 1'b0);
        want_byte(8'h0D, "R8 data write reply");
        send(8'h44); send(8'h77);
        drain("R8 drain");

        // R9 erase, R10 long wait
        want_frame(32'hAC80_0400, "R9 erase frame", 1'b0);
        want_byte(8'h0D, "R9 erase reply");
        send(8'h65);
        drain("R9 drain");
        gap_check(LW, LW + 40, "R10 erase wait");
        // R9 signature bytes
        want_frame(32'h3000_0200, "R9 sig 2", 1'b1);
        want_frame(32'h3000_0100, "R9 sig 1", 1'b1);
        want_frame(32'h3000_0000, "R9 sig 0", 1'b1);
        send(8'h73);
        drain("R9 drain2");

        // R10 page write
        want_frame({8'h4C, addr_m, 8'h00}, "R10 page frame", 1'b0);
        want_byte(8'h0D, "R10 page reply");
        send(8'h6D);
        drain("R10 drain");
        gap_check(LW, LW + 40, "R10 page wait");

        // R11 raw frame
        want_frame(32'h1122_3300, "R11 raw frame", 1'b1);
        want_byte(8'h0D, "R11 raw reply");
        send(8'h3A); send(8'h11); send(8'h22); send(8'h33);
        drain("R11 drain");

        // R12 identity replies
        for (int i = 0; i < 7; i++) want_byte(id[i], "R12 ident");
        send(8'h53);
        want_byte(8'h33, "R12 sw major"); want_byte(8'h31, "R12 sw minor");
        send(8'h56);
        want_byte(8'h31, "R12 hw major"); want_byte(8'h32, "R12 hw minor");
        send(8'h76);
        want_byte(8'h12, "R12 list"); want_byte(8'h13, "R12 list");
        want_byte(8'h20, "R12 list"); want_byte(8'h28, "R12 list");
        want_byte(8'h38, "R12 list"); want_byte(8'h48, "R12 list");
        want_byte(8'h86, "R12 list"); want_byte(8'h00, "R12 list end");
        send(8'h74);
        drain("R12 drain");

        // R7 byte-wide target
        want_byte(8'h0D, "R7 select byte-wide");
        send(8'h54); send(8'h86);
        want_byte(8'h0D, "R7 address");
        send(8'h41); send(8'h05); send(8'h0F);
        drain("R7 drain");
        for (int n = 0; n < 2; n++)
            want_frame(32'h2829_0F00, "R7 byte-wide read no inc", 1'b1);
        send(8'h52); send(8'h52);
        want_frame(32'h402A_0F11, "R7 byte-wide write", 1'b0);
        want_byte(8'h0D, "R7 write reply");
        send(8'h63); send(8'h11);
        drain("R7 drain2");
        want_byte(8'h3F, "R7 high write rejected");
        want_byte(8'h53, "R7 data byte consumed");
        send(8'h43); send(8'h70); send(8'h70);
        // the second 0x70 is the probe; the first was swallowed as data
        want_frame(32'hA02D_0F00, "R7 byte-wide data read", 1'b1);
        send(8'h64);
        want_frame(32'hC02E_0F33, "R7 byte-wide data write", 1'b0);
        want_byte(8'h0D, "R7 data write reply");
        send(8'h44); send(8'h33);
        drain("R7 drain3");

        // R10 page-mode device skips per-byte wait
        want_byte(8'h0D, "R10 select page device");
        send(8'h54); send(8'h40);
        drain("R10 drain2");
        want_frame({8'h40, 16'h050F, 8'h55}, "R10 page-mode write", 1'b0);
        want_byte(8'h0D, "R10 page-mode reply");
        send(8'h63); send(8'h55);
        drain("R10 drain3");
        gap_check(0, WW, "R10 no wait on page device");

        // R13 leave
        want_byte(8'h0D, "R13 leave");
        send(8'h4C);
        drain("R13 drain2");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule